// File: doc/BRIEF.md
# CRC-Gated Multi-Slot Frame Buffer

This block takes in Ethernet frames as a stream of 9-bit words. Bit 8 of a word is the start bit and marks the first byte of the destination MAC address. A separate `in_last` flag marks the final byte of the frame. Each new frame is steered into a free single-frame slot. While the bytes are written, a built-in CRC-32 engine folds them in. When the last byte arrives, the slot is committed only if the frame check sequence is correct. Otherwise the slot is flushed and becomes free again. A frame that finds no free slot when it starts is thrown away in full.

Committed slots are emptied by a round-robin drainer onto one 9-bit output stream. Each drained frame appears exactly as received, including its four FCS bytes. Bit 8 is set again on the first byte of the frame, and `out_last` is raised on its final byte.

Back-pressure rules: the input side never stalls. `in_ready` is high whenever the block is out of reset, and frames that cannot be stored are dropped rather than held off. The output side is valid/ready. A byte transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word and `out_last` hold their values.

Top module: `frame_slot_buffer`

## Requirements
- R1: During reset and at the first sampling after it, `out_valid` is low. `in_ready` is high from the second clock edge after reset release onward.
- R2: The CRC uses the reflected form of polynomial 0x04C11DB7 (shift-right constant 0xEDB88320) with a register initialised to all ones. It is run over every byte of the frame, FCS included, with the FCS sent least significant byte first. A frame whose register ends at 0xDEBB20E3 (the bit-reversed form of 0xC704DD7B) is committed and later output byte for byte, FCS included.
- R3: A frame whose CRC register does not end at that residue is flushed and produces no output.
- R4: On the output, bit 8 is 1 on the first byte of each frame and 0 on every other byte. `out_last` is 1 only on the final byte.
- R5: A start-bit word that arrives while a frame is still open ends that frame as bad (it is flushed) and begins a new frame with that word.
- R6: A slot holds up to SLOT_BYTES bytes. A frame of exactly SLOT_BYTES bytes is delivered. A longer frame is flushed, and its remaining bytes up to `in_last` are discarded.
- R7: If no slot is free when a start-bit word arrives, that whole frame is dropped. Frames already stored are still delivered.
- R8: Committed slots are drained one whole frame at a time, in round-robin order. The search begins at the slot after the one drained last. New frames claim the lowest-numbered free slot.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R10: Words without a start bit that arrive outside an open frame are ignored, including any `in_last` on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 9 | Input word: bit 8 start bit, bits 7:0 frame byte |
| in_valid | input | 1 | Input word valid |
| in_last | input | 1 | Marks the final byte (last FCS byte) of a frame |
| in_ready | output | 1 | Input accepted; high whenever out of reset |
| out_data | output | 9 | Output word: bit 8 set on the first byte of a frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_last | output | 1 | Final byte of the frame being drained |

## Verification
The main function is tried with a table of frames. The table holds good frames of several lengths, including one made only of the four FCS bytes, frames whose last FCS byte is corrupted, a frame that exactly fills a slot, and one that is a single byte too long. Together these separate a commit from a flush and check the slot-size boundary from both sides. Directed patterns then cover three more cases: a frame cut short by a new start bit, and stray non-start words before a frame. The third fills all slots under output stall so a fourth frame is dropped. A sequence that frees slot 0 while slots 1 and 2 are still full tells round-robin draining apart from fixed-priority draining. A long output stall checks that the held word is stable.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  // Reflected CRC-32 shift constant and check values.
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
  // Register value left by a frame whose own FCS is appended correctly.
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_FULL = 2'd2
  } slot_state_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_FILL = 2'd1,
    WR_DROP = 2'd2
  } wr_state_e;

  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fsb_crc32.sv
module fsb_crc32
  import fsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,   // fold byte onto the seed
  input  logic        step,      // fold byte onto running value
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_next
);

  logic [31:0] crc_q;

  assign crc_next = crc_fold(restart ? CRC_SEED : crc_q, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_q <= CRC_SEED;
    else if (restart || step)  crc_q <= crc_next;
  end

endmodule

// File: rtl/fsb_slot.sv
module fsb_slot
  import fsb_pkg::*;
#(
  parameter int SLOT_BYTES = 512,
  localparam int AW = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int LW = $clog2(SLOT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic          good,
  input  logic          bad,
  input  logic          release_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic [LW-1:0] commit_len,
  input  logic [AW-1:0] rd_addr,
  output logic          is_free,
  output logic          is_full,
  output logic [LW-1:0] len,
  output logic [7:0]    rd_byte
);

  slot_state_e st_q;
  logic [7:0]  mem [SLOT_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SLOT_FREE;
      len  <= '0;
    end else begin
      unique case (st_q)
        SLOT_FREE: if (claim) st_q <= SLOT_FILL;
        SLOT_FILL: begin
          if (good) begin
            st_q <= SLOT_FULL;
            len  <= commit_len;
          end else if (bad) begin
            st_q <= SLOT_FREE;
          end
        end
        SLOT_FULL: if (release_i) st_q <= SLOT_FREE;
        default:   st_q <= SLOT_FREE;
      endcase
    end
  end

  assign is_free = (st_q == SLOT_FREE);
  assign is_full = (st_q == SLOT_FULL);

  // R7
  claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> st_q == SLOT_FREE);
  // R2
  good_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> (st_q == SLOT_FILL && !bad));
  // R3
  bad_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> st_q == SLOT_FILL);
  // R8
  release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> st_q == SLOT_FULL);

endmodule

// File: rtl/fsb_writer.sv
module fsb_writer
  import fsb_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 512,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int AW = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int LW = $clog2(SLOT_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8:0]           in_data,
  input  logic                 in_valid,
  input  logic                 in_last,
  output logic                 in_ready,
  input  logic [NUM_SLOTS-1:0] free_vec,
  output logic [NUM_SLOTS-1:0] claim_vec,
  output logic [NUM_SLOTS-1:0] good_vec,
  output logic [NUM_SLOTS-1:0] bad_vec,
  output logic [NUM_SLOTS-1:0] wr_en_vec,
  output logic [AW-1:0]        wr_addr,
  output logic [7:0]           wr_byte,
  output logic [LW-1:0]        commit_len
);

  wr_state_e    st_q, st_n;
  logic [SW-1:0] cur_q, cur_n;
  logic [LW-1:0] ptr_q, ptr_n;
  logic          ready_q;
  logic          fire;
  logic          any_free;
  logic [SW-1:0] alloc;
  logic          crc_restart, crc_step;
  logic [31:0]   crc_next;
  logic          wr_en;
  logic [SW-1:0] wr_slot;

  assign in_ready = ready_q;
  assign fire     = in_valid && ready_q;
  assign wr_byte  = in_data[7:0];

  fsb_crc32 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (crc_restart),
    .step     (crc_step),
    .byte_in  (in_data[7:0]),
    .crc_next (crc_next)
  );

  // Lowest-numbered free slot.
  always_comb begin
    any_free = 1'b0;
    alloc    = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        alloc    = SW'(i);
      end
    end
  end

  always_comb begin
    st_n        = st_q;
    cur_n       = cur_q;
    ptr_n       = ptr_q;
    claim_vec   = '0;
    good_vec    = '0;
    bad_vec     = '0;
    wr_en       = 1'b0;
    wr_slot     = cur_q;
    wr_addr     = ptr_q[AW-1:0];
    crc_restart = 1'b0;
    crc_step    = 1'b0;
    commit_len  = ptr_q + LW'(1);
    if (fire) begin
      if (in_data[8]) begin
        if (st_q == WR_FILL) bad_vec[cur_q] = 1'b1;
        if (in_last) begin
          st_n = WR_IDLE;             // one-byte frame cannot carry a good FCS
        end else if (any_free) begin
          claim_vec[alloc] = 1'b1;
          wr_en       = 1'b1;
          wr_slot     = alloc;
          wr_addr     = '0;
          crc_restart = 1'b1;
          cur_n       = alloc;
          ptr_n       = LW'(1);
          st_n        = WR_FILL;
        end else begin
          st_n = WR_DROP;
        end
      end else if (st_q == WR_FILL) begin
        if (ptr_q == LW'(SLOT_BYTES)) begin
          bad_vec[cur_q] = 1'b1;
          st_n = in_last ? WR_IDLE : WR_DROP;
        end else begin
          wr_en    = 1'b1;
          crc_step = 1'b1;
          ptr_n    = ptr_q + LW'(1);
          if (in_last) begin
            if (crc_next == CRC_RESIDUE) good_vec[cur_q] = 1'b1;
            else                         bad_vec[cur_q]  = 1'b1;
            st_n = WR_IDLE;
          end
        end
      end else if (st_q == WR_DROP) begin
        if (in_last) st_n = WR_IDLE;
      end
    end
  end

  always_comb begin
    wr_en_vec = '0;
    if (wr_en) wr_en_vec[wr_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_IDLE;
      cur_q   <= '0;
      ptr_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      ptr_q   <= ptr_n;
      ready_q <= 1'b1;
    end
  end

  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LW'(SLOT_BYTES));
  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != WR_FILL && !in_data[8]) |-> wr_en_vec == '0);

endmodule

// File: rtl/fsb_drainer.sv
module fsb_drainer #(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 512,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int AW = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int LW = $clog2(SLOT_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] full_vec,
  input  logic [LW-1:0]        len_arr  [NUM_SLOTS],
  input  logic [7:0]           byte_arr [NUM_SLOTS],
  output logic [AW-1:0]        rd_addr,
  output logic [NUM_SLOTS-1:0] release_vec,
  output logic [8:0]           out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_last
);

  logic          busy_q;
  logic [SW-1:0] sel_q, prev_q, pick;
  logic [LW-1:0] rd_q;
  logic          found;
  logic          fire;

  // Round-robin search starting after the slot drained last.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      int idx;
      idx = int'(prev_q) + k;
      if (idx >= NUM_SLOTS) idx = idx - NUM_SLOTS;
      if (!found && full_vec[idx]) begin
        found = 1'b1;
        pick  = SW'(idx);
      end
    end
  end

  assign rd_addr   = rd_q[AW-1:0];
  assign out_valid = busy_q;
  assign out_data  = {rd_q == '0, byte_arr[sel_q]};
  assign out_last  = busy_q && (rd_q == len_arr[sel_q] - LW'(1));
  assign fire      = busy_q && out_ready;

  always_comb begin
    release_vec = '0;
    if (fire && out_last) release_vec[sel_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      prev_q <= SW'(NUM_SLOTS - 1);
      rd_q   <= '0;
    end else if (busy_q) begin
      if (fire) begin
        if (out_last) begin
          busy_q <= 1'b0;
          prev_q <= sel_q;
        end else begin
          rd_q <= rd_q + LW'(1);
        end
      end
    end else if (found) begin
      busy_q <= 1'b1;
      sel_q  <= pick;
      rd_q   <= '0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R4
  no_midframe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && !out_data[8]));
  // R8
  one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_vec));

endmodule

// File: rtl/frame_slot_buffer.sv
module frame_slot_buffer #(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 512,
  localparam int AW = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int LW = $clog2(SLOT_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [8:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_last
);

  logic [NUM_SLOTS-1:0] free_vec, full_vec;
  logic [NUM_SLOTS-1:0] claim_vec, good_vec, bad_vec, wr_en_vec, release_vec;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic [7:0]           wr_byte;
  logic [LW-1:0]        commit_len;
  logic [LW-1:0]        len_arr  [NUM_SLOTS];
  logic [7:0]           byte_arr [NUM_SLOTS];

  fsb_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .free_vec   (free_vec),
    .claim_vec  (claim_vec),
    .good_vec   (good_vec),
    .bad_vec    (bad_vec),
    .wr_en_vec  (wr_en_vec),
    .wr_addr    (wr_addr),
    .wr_byte    (wr_byte),
    .commit_len (commit_len)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    fsb_slot #(.SLOT_BYTES(SLOT_BYTES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim      (claim_vec[g]),
      .good       (good_vec[g]),
      .bad        (bad_vec[g]),
      .release_i  (release_vec[g]),
      .wr_en      (wr_en_vec[g]),
      .wr_addr    (wr_addr),
      .wr_byte    (wr_byte),
      .commit_len (commit_len),
      .rd_addr    (rd_addr),
      .is_free    (free_vec[g]),
      .is_full    (full_vec[g]),
      .len        (len_arr[g]),
      .rd_byte    (byte_arr[g])
    );
  end

  fsb_drainer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_drainer (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_vec    (full_vec),
    .len_arr     (len_arr),
    .byte_arr    (byte_arr),
    .rd_addr     (rd_addr),
    .release_vec (release_vec),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_last    (out_last)
  );

endmodule

// File: tb/frame_slot_buffer_bench.sv
`timescale 1ns/1ps
module frame_slot_buffer_bench;

  localparam int NSL = 3;
  localparam int SB  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic       in_ready, out_valid, out_last;
  logic [8:0] out_data;

  always #2.5 clk = ~clk;

  frame_slot_buffer #(.NUM_SLOTS(NSL), .SLOT_BYTES(SB)) u_frame_slot_buffer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] fb [0:127];
  int flen;
  logic [7:0] rx_d [0:511];
  logic       rx_s [0:511];
  logic       rx_l [0:511];
  int rx_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rx_cnt < 512) begin
      rx_d[rx_cnt] = out_data[7:0];
      rx_s[rx_cnt] = out_data[8];
      rx_l[rx_cnt] = out_last;
      rx_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // payload[i] = seed + i, then FCS least significant byte first
  task automatic build(input int plen, input logic [7:0] seed, input bit corrupt);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < plen; i++) begin
      fb[i] = seed + 8'(i);
      c = c ^ {24'd0, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int b = 0; b < 4; b++) fb[plen + b] = c[8*b +: 8];
    flen = plen + 4;
    if (corrupt) fb[flen-1] = fb[flen-1] ^ 8'h01;
  endtask

  task automatic send(input int n, input bit with_start, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = {with_start && i == 0, fb[i]};
      in_last  = with_last && i == n - 1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Compares the capture buffer with the frame in fb.
  task automatic match_frame(input string req);
    bit dok, fok;
    dok = (rx_cnt == flen);
    fok = dok;
    for (int j = 0; j < rx_cnt && j < flen; j++) begin
      if (rx_d[j] != fb[j]) dok = 0;
      if (rx_s[j] != (j == 0) || rx_l[j] != (j == flen - 1)) fok = 0;
    end
    check(dok, {req, " bytes"}, rx_cnt, flen);
    check(fok, "R4 start/last flags", fok, 1);
  endtask

  task automatic heads(output logic [7:0] h [0:7], output int nh);
    nh = 0;
    for (int j = 0; j < rx_cnt; j++)
      if (rx_s[j] && nh < 8) begin h[nh] = rx_d[j]; nh++; end
  endtask

  // {payload length, seed, kind}: kind 0 good, 1 bad FCS, 2 one byte over slot
  localparam logic [17:0] VEC [0:6] = '{
    {8'd10, 8'h10, 2'd0},
    {8'd0,  8'h20, 2'd0},
    {8'd20, 8'h30, 2'd1},
    {8'd60, 8'h40, 2'd0},
    {8'd61, 8'h50, 2'd2},
    {8'd46, 8'h60, 2'd0},
    {8'd33, 8'h70, 2'd1}
  };

  initial begin
    #(100000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] h [0:7];
    int nh;
    logic [8:0] held;

    // R1 reset state
    repeat (3) @(posedge clk); #1;
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 0, "R1 in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    idle(2);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);

    // Table walk: R2, R3, R6
    for (int v = 0; v < 7; v++) begin
      rx_cnt = 0;
      build(int'(VEC[v][17:10]), VEC[v][9:2], VEC[v][1:0] == 2'd1);
      send(flen, 1, 1);
      idle(flen + 20);
      if (VEC[v][1:0] == 2'd0) match_frame(flen == SB ? "R6 full slot" : "R2 good frame");
      else check(rx_cnt == 0, VEC[v][1:0] == 2'd1 ? "R3 bad FCS flushed" : "R6 overflow flushed",
                 rx_cnt, 0);
    end

    // R5: frame cut short by a new start bit
    rx_cnt = 0;
    build(20, 8'h80, 0);
    send(10, 1, 0);
    build(12, 8'h90, 0);
    send(flen, 1, 1);
    idle(40);
    match_frame("R5 interrupted frame");

    // R10: stray words outside a frame
    rx_cnt = 0;
    build(6, 8'hA0, 0);
    send(5, 0, 1);
    send(flen, 1, 1);
    idle(40);
    match_frame("R10 stray words ignored");

    // R8 round robin and R9 hold
    rx_cnt = 0;
    out_ready = 1'b0;
    build(8, 8'hA1, 0); send(flen, 1, 1);
    build(8, 8'hB1, 0); send(flen, 1, 1);
    build(8, 8'hC1, 0); send(flen, 1, 1);
    idle(3);
    out_ready = 1'b1;
    wait (rx_cnt == 12);
    @(posedge clk); #1;
    out_ready = 1'b0;
    idle(3);
    held = out_data;
    build(8, 8'hD1, 0); send(flen, 1, 1);
    check(out_valid && out_data == held, "R9 word held under stall", out_data, held);
    out_ready = 1'b1;
    idle(80);
    heads(h, nh);
    check(rx_cnt == 48, "R8 byte count", rx_cnt, 48);
    check(nh == 4 && h[0] == 8'hA1 && h[1] == 8'hB1 && h[2] == 8'hC1 && h[3] == 8'hD1,
          "R8 round-robin order", {h[2], h[3]}, 16'hC1D1);

    // R7: all slots busy, fourth frame dropped
    rx_cnt = 0;
    out_ready = 1'b0;
    build(8, 8'hE1, 0); send(flen, 1, 1);
    build(8, 8'hF1, 0); send(flen, 1, 1);
    build(8, 8'h11, 0); send(flen, 1, 1);
    build(8, 8'h21, 0); send(flen, 1, 1);
    idle(3);
    out_ready = 1'b1;
    idle(80);
    heads(h, nh);
    check(rx_cnt == 36, "R7 dropped frame absent", rx_cnt, 36);
    check(nh == 3 && h[0] == 8'hE1 && h[1] == 8'hF1 && h[2] == 8'h11,
          "R7 stored frames delivered", nh, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule